// File: doc/BRIEF.md
# Dual-Direction Processor Mailbox

The block lets an application processor and an I/O processor pass short messages to each other through a shared register window. It holds two independent message queues. The outbound queue carries traffic from the application side to the I/O side, and the inbound queue carries traffic the other way. Each message is 96 bits: a 64-bit leading word and a 32-bit trailing payload. A sender first writes the leading word into a staging register. It then writes the trailing word, and that write commits the whole message. The receiver can peek at the leading word of the oldest message. Reading the trailing word removes that message and also returns occupancy and pointer information in the upper bits.

Four status conditions are latched into sticky flags: outbound empty, outbound non-empty, inbound empty and inbound non-empty. A flag stays set until software writes a one to its bit in the acknowledge register. The flags are masked by an enable register and combined into one level interrupt per processor. Inside the block, each queue is a valid/ready stream. A message is accepted only when the queue has room. There is no back-pressure toward the bus: a commit into a full queue is dropped and recorded in a sticky overflow bit. A pop from an empty queue does nothing.

The depth parameter `DEPTH` must lie between 2 and 15, so that every occupancy and pointer value fits its 4-bit status field.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty and both enables and all overflow bits are cleared. Reading a control register returns only bit 17 (empty) set, and both interrupt outputs are low.
- R2: A write to a queue's leading-word send register (outbound 0x60, inbound 0x90) changes only the staging register. The queue occupancy reported by the control register (outbound 0x50, inbound 0x80) does not change.
- R3: A write to the trailing-word send register (outbound 0x68, inbound 0x98) commits the message when the queue is not full. The message is the staged leading word plus write data [31:0]. Messages leave in the order they were committed, and each direction is independent.
- R4: Control register bit 16 reads 1 when the queue holds DEPTH messages. A commit into a full queue is dropped and sets bit 18 (overflow). Writing a 1 to bit 18 of the control register clears it.
- R5: Reading the leading-word receive register (outbound 0x70, inbound 0xA0) returns the oldest message's leading word and does not remove it. Reading the trailing-word receive register (outbound 0x78, inbound 0xA8) returns its payload in bits [31:0] and removes it.
- R6: A trailing-word read also returns status taken before the pop, with all other bits zero. Bits [56:52] hold this queue's occupancy, [51:48] the other queue's occupancy, [47:44] this queue's read pointer and [43:40] its write pointer.
- R7: Reads of either receive register while the queue is empty return zero and leave the occupancy and pointers unchanged.
- R8: The flag bits are: bit 0 outbound empty, bit 1 outbound non-empty, bit 2 inbound empty, bit 3 inbound non-empty. A flag is set in the cycle after its condition holds and stays set until a 1 is written to that bit at 0x4C. A read of 0x4C returns the flags.
- R9: If a flag's condition still holds when its acknowledge is written, the flag reads 1 in the following cycle.
- R10: The enable register at 0x48 holds bits [3:0]. irq_app is the OR of flags 0 and 3 ANDed with their enables. irq_io is the OR of flags 1 and 2 ANDed with their enables. Both outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from address and state |
| irq_app | output | 1 | Level interrupt to the application processor |
| irq_io | output | 1 | Level interrupt to the I/O processor |

## Verification
The bench fills the outbound queue past its depth. A design that let the extra commit through, or forgot to set the overflow bit, would report the wrong occupancy or order on the later pops. It pops both queues while checking the status fields. An off-by-one pointer wrap or status sampled after the pop shows up in bits [56:40]. It then acknowledges flags whose conditions still hold and flags whose conditions have gone away. A design whose flags followed the condition directly would drop a flag too early, and one that ignored the acknowledge would never clear it. Reads and pops on empty queues are checked for zero data and unchanged pointers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] ADDR_IRQ_EN  = 8'h48;
  localparam logic [7:0] ADDR_IRQ_ACK = 8'h4C;
  localparam logic [7:0] BASE_OUT     = 8'h50;
  localparam logic [7:0] BASE_IN      = 8'h80;
  localparam logic [7:0] OFS_SEND_LO  = 8'h10;
  localparam logic [7:0] OFS_SEND_HI  = 8'h18;
  localparam logic [7:0] OFS_RECV_LO  = 8'h20;
  localparam logic [7:0] OFS_RECV_HI  = 8'h28;

  localparam int BIT_FULL  = 16;
  localparam int BIT_EMPTY = 17;
  localparam int BIT_OVF   = 18;

  // flag masks routed to each processor
  localparam logic [3:0] APP_MASK = 4'b1001;
  localparam logic [3:0] IO_MASK  = 4'b0110;

  typedef struct packed {
    logic [63:0] lead;
    logic [31:0] tail;
  } mbx_msg_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 96,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    level,
  output logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    wr_ptr
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic wr_fire, rd_fire;

  assign in_ready  = (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign wr_fire   = in_valid & in_ready;
  assign rd_fire   = out_valid & out_ready;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= step(wr_ptr);
      if (rd_fire) rd_ptr <= step(rd_ptr);
      case ({wr_fire, rd_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel import mbx_pkg::*; #(
  parameter int DEPTH = 8,
  parameter logic [7:0] BASE = 8'h50,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [63:0]   bus_wdata,
  input  logic [3:0]    peer_level,
  output logic [63:0]   rd_data,
  output logic          is_empty,
  output logic          is_full,
  output logic          ovf_flag,
  output logic [CW-1:0] level
);
  logic hit_ctrl, hit_slo, hit_shi, hit_rlo, hit_rhi;
  logic [63:0] stage_q;
  logic push, pop_req, in_ready, out_valid;
  mbx_msg_t in_msg, head;
  logic [PW-1:0] rd_ptr, wr_ptr;

  assign hit_ctrl = (bus_addr == BASE);
  assign hit_slo  = (bus_addr == BASE + OFS_SEND_LO);
  assign hit_shi  = (bus_addr == BASE + OFS_SEND_HI);
  assign hit_rlo  = (bus_addr == BASE + OFS_RECV_LO);
  assign hit_rhi  = (bus_addr == BASE + OFS_RECV_HI);

  assign push    = bus_wr & hit_shi;   // R3: commit on trailing word
  assign pop_req = bus_rd & hit_rhi;   // R5: pop on trailing-word read
  assign in_msg  = '{lead: stage_q, tail: bus_wdata[31:0]};

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH($bits(mbx_msg_t))) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(push), .in_ready(in_ready), .in_data(in_msg),
    .out_valid(out_valid), .out_ready(pop_req), .out_data(head),
    .level(level), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
  );

  assign is_empty = ~out_valid;
  assign is_full  = ~in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (bus_wr && hit_slo) stage_q <= bus_wdata;   // R2: staging only
      if (bus_wr && hit_ctrl && bus_wdata[BIT_OVF]) ovf_flag <= 1'b0;
      else if (push && !in_ready) ovf_flag <= 1'b1;  // R4
    end
  end

  always_comb begin
    rd_data = '0;
    if (bus_rd) begin
      if (hit_ctrl) begin
        rd_data[BIT_FULL]  = is_full;
        rd_data[BIT_EMPTY] = is_empty;
        rd_data[BIT_OVF]   = ovf_flag;
      end else if (hit_rlo && out_valid) begin
        rd_data = head.lead;
      end else if (hit_rhi && out_valid) begin   // R6 status fields
        rd_data[56:52] = 5'(level);
        rd_data[51:48] = peer_level;
        rd_data[47:44] = 4'(rd_ptr);
        rd_data[43:40] = 4'(wr_ptr);
        rd_data[31:0]  = head.tail;
      end
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq import mbx_pkg::*; #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] cond,
  input  logic             en_wr,
  input  logic             ack_wr,
  input  logic [NFLAG-1:0] wr_bits,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] enables,
  output logic             irq_app,
  output logic             irq_io
);
  logic [NFLAG-1:0] masked;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    // R8/R9: sticky, and set again at once if the condition survives the ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= cond[i] | (flags[i] & ~(ack_wr & wr_bits[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enables <= '0;
    else if (en_wr) enables <= wr_bits;
  end

  assign masked = flags & enables;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_app <= 1'b0;
      irq_io  <= 1'b0;
    end else begin
      irq_app <= |(masked & APP_MASK);  // R10
      irq_io  <= |(masked & IO_MASK);
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbx_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        irq_app,
  output logic        irq_io
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [63:0]   chan_rd [2];
  logic [CW-1:0] lvl [2];
  logic [1:0]    empty_v, full_v, ovf_v;
  logic [3:0]    flag_q, en_q, cond;
  logic [63:0]   irq_rd;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    mbx_channel #(.DEPTH(DEPTH), .BASE(d == 0 ? BASE_OUT : BASE_IN)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .peer_level(4'(lvl[1-d])),
      .rd_data(chan_rd[d]), .is_empty(empty_v[d]), .is_full(full_v[d]),
      .ovf_flag(ovf_v[d]), .level(lvl[d])
    );
  end

  assign cond = {~empty_v[1], empty_v[1], ~empty_v[0], empty_v[0]};

  mbx_irq #(.NFLAG(4)) irq_i (
    .clk(clk), .rst_n(rst_n), .cond(cond),
    .en_wr(bus_wr && bus_addr == ADDR_IRQ_EN),
    .ack_wr(bus_wr && bus_addr == ADDR_IRQ_ACK),
    .wr_bits(bus_wdata[3:0]),
    .flags(flag_q), .enables(en_q),
    .irq_app(irq_app), .irq_io(irq_io)
  );

  always_comb begin
    irq_rd = '0;
    if (bus_rd && bus_addr == ADDR_IRQ_EN)  irq_rd[3:0] = en_q;
    if (bus_rd && bus_addr == ADDR_IRQ_ACK) irq_rd[3:0] = flag_q;
  end

  assign bus_rdata = chan_rd[0] | chan_rd[1] | irq_rd;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker import mbx_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_addr,
  input logic [3:0]    ack_bits,
  input logic [3:0]    flags,
  input logic [1:0]    full,
  input logic [1:0]    empty,
  input logic [1:0]    ovf,
  input logic [CW-1:0] lvl_out,
  input logic [CW-1:0] lvl_in
);
  localparam logic [7:0] OUT_SHI = BASE_OUT + OFS_SEND_HI;
  localparam logic [7:0] OUT_RHI = BASE_OUT + OFS_RECV_HI;
  localparam logic [7:0] IN_SHI  = BASE_IN + OFS_SEND_HI;

  logic [3:0] ackm, keep;
  assign ackm = (bus_wr && bus_addr == ADDR_IRQ_ACK) ? ack_bits : 4'b0;
  assign keep = flags & ~ackm;

  assert_drop_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == OUT_SHI && full[0]) |=> (lvl_out == $past(lvl_out) && ovf[0]));

  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == IN_SHI && !full[1]) |=> (lvl_in == CW'($past(lvl_in) + 1'b1)));

  assert_empty_pop_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == OUT_RHI && empty[0]) |=> (lvl_out == $past(lvl_out)));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != 4'b0) |=> ((flags & $past(keep)) == $past(keep)));

  assert_refire_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty[0] |=> flags[0]);

  assert_refire_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty[1] |=> flags[3]);
endmodule

bind ipc_mailbox mbx_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .ack_bits(bus_wdata[3:0]), .flags(flag_q), .full(full_v), .empty(empty_v),
  .ovf(ovf_v), .lvl_out(lvl[0]), .lvl_in(lvl[1])
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb_top;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic irq_app, irq_io;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  ipc_mailbox #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_app(irq_app), .irq_io(irq_io)
  );

  always #2 clk = ~clk;   // 250 MHz

  // ---------------- behavioural reference model ----------------
  logic [95:0] q_out[$], q_in[$];
  logic [63:0] mstage [2];
  logic        movf [2];
  int          mrp [2], mwp [2];
  logic [3:0]  mflags = '0, men = '0, mirq_app_q = '0, cnd, ackm;
  logic        m_irq_app = 1'b0, m_irq_io = 1'b0;

  function automatic logic [7:0] base(input int d);
    return d == 0 ? 8'h50 : 8'h80;
  endfunction
  function automatic int msize(input int d);
    return d == 0 ? q_out.size() : q_in.size();
  endfunction
  function automatic logic [95:0] mhead(input int d);
    return d == 0 ? q_out[0] : q_in[0];
  endfunction

  function automatic logic [63:0] mexp(input logic [7:0] a);
    logic [63:0] r = '0;
    if (a == 8'h48) r[3:0] = men;
    if (a == 8'h4C) r[3:0] = mflags;
    for (int d = 0; d < 2; d++) begin
      if (a == base(d)) begin
        r[16] = (msize(d) == DEPTH);
        r[17] = (msize(d) == 0);
        r[18] = movf[d];
      end
      if (a == base(d) + 8'h20 && msize(d) > 0) r = mhead(d)[95:32];
      if (a == base(d) + 8'h28 && msize(d) > 0) begin
        r[56:52] = 5'(msize(d));
        r[51:48] = 4'(msize(1 - d));
        r[47:44] = 4'(mrp[d]);
        r[43:40] = 4'(mwp[d]);
        r[31:0]  = mhead(d)[31:0];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_out.delete(); q_in.delete();
      for (int d = 0; d < 2; d++) begin mstage[d] = '0; movf[d] = 1'b0; mrp[d] = 0; mwp[d] = 0; end
      mflags = '0; men = '0; m_irq_app = 1'b0; m_irq_io = 1'b0;
    end else begin
      m_irq_app = |(mflags & men & 4'b1001);
      m_irq_io  = |(mflags & men & 4'b0110);
      cnd  = {q_in.size() != 0, q_in.size() == 0, q_out.size() != 0, q_out.size() == 0};
      ackm = (bus_wr && bus_addr == 8'h4C) ? bus_wdata[3:0] : 4'b0;
      mflags = cnd | (mflags & ~ackm);
      if (bus_wr) begin
        if (bus_addr == 8'h48) men = bus_wdata[3:0];
        for (int d = 0; d < 2; d++) begin
          if (bus_addr == base(d) && bus_wdata[18]) movf[d] = 1'b0;
          if (bus_addr == base(d) + 8'h10) mstage[d] = bus_wdata;
          if (bus_addr == base(d) + 8'h18) begin
            if (msize(d) < DEPTH) begin
              if (d == 0) q_out.push_back({mstage[d], bus_wdata[31:0]});
              else        q_in.push_back({mstage[d], bus_wdata[31:0]});
              mwp[d] = (mwp[d] + 1) % DEPTH;
            end else movf[d] = 1'b1;
          end
        end
      end
      if (bus_rd) begin
        for (int d = 0; d < 2; d++) begin
          if (bus_addr == base(d) + 8'h28 && msize(d) > 0) begin
            if (d == 0) void'(q_out.pop_front());
            else        void'(q_in.pop_front());
            mrp[d] = (mrp[d] + 1) % DEPTH;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle interrupt comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq_app", {63'b0, irq_app}, {63'b0, m_irq_app});
      check("R10 irq_io",  {63'b0, irq_io},  {63'b0, m_irq_io});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(tag, bus_rdata, mexp(a));
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic send(input int d, input logic [63:0] lead, input logic [31:0] tail);
    wr(base(d) + 8'h10, lead);
    wr(base(d) + 8'h18, {32'hDEAD_BEEF, tail});
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog (all): got cycle %0d expected below 50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state (exact values also stated here)
    @(negedge clk);
    check("R1 irq_app low", {63'b0, irq_app}, 64'd0);
    rd(8'h50, "R1 outbound ctrl");
    check("R1 ctrl literal", mexp(8'h50), 64'h0002_0000);
    rd(8'h80, "R1 inbound ctrl");
    rd(8'h48, "R1 enables");
    // R10 enable app-side flags
    wr(8'h48, 64'h9);
    rd(8'h48, "R10 enable readback");
    // R9 ack while outbound still empty
    wr(8'h4C, 64'h1);
    rd(8'h4C, "R9 refire after ack");
    // R2 staging only
    wr(8'h60, 64'h1111_2222_3333_4444);
    rd(8'h50, "R2 still empty");
    // R3 commit
    wr(8'h68, 64'hFFFF_0000_AAAA_0001);
    rd(8'h50, "R3 not empty");
    rd(8'h70, "R5 peek lead");
    rd(8'h70, "R5 peek again no pop");
    rd(8'h4C, "R8 sticky empty flag");
    wr(8'h4C, 64'h1);
    rd(8'h4C, "R8 ack clears");
    wr(8'h4C, 64'h2);
    rd(8'h4C, "R9 nonempty refire");
    // R4 fill and overflow
    for (int i = 1; i < DEPTH + 1; i++) send(0, 64'hA000_0000_0000_0000 + i, 32'h100 + i);
    rd(8'h50, "R4 full and overflow");
    wr(8'h50, 64'h4_0000);
    rd(8'h50, "R4 overflow cleared");
    // R3 inbound independent
    for (int i = 0; i < 3; i++) send(1, 64'hB000_0000_0000_0000 + i, 32'h200 + i);
    rd(8'h80, "R3 inbound ctrl");
    // R5/R6 drain outbound
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h70, "R5 lead word");
      rd(8'h78, "R6 tail and status");
    end
    rd(8'h78, "R7 empty tail read");
    rd(8'h70, "R7 empty lead read");
    rd(8'h50, "R7 ctrl after empty pops");
    // R6 inbound drain
    for (int i = 0; i < 3; i++) rd(8'hA8, "R6 inbound tail");
    rd(8'hA8, "R7 inbound empty");
    wr(8'h4C, 64'hF);
    rd(8'h4C, "R8 ack all");
    // R10 I/O side
    wr(8'h48, 64'h6);
    send(0, 64'h5, 32'h6);
    repeat (3) @(negedge clk);
    rd(8'h78, "R6 final pop");
    repeat (3) @(negedge clk);
    rd(8'h4C, "R8 final flags");
    finish_run();
  end
endmodule